// File: doc/BRIEF.md
# Block-Granular Dual FIFO Work Scheduler

This block sits between a host register interface and a set of cryptographic compute engines. The host pushes 32-bit words into an input queue and pops result words from an output queue. The input queue holds 32 words and the output queue holds 33 words. A status word gives the number of free input slots and the number of output words waiting. The host reads the status to pace its traffic.

The scheduler decides when one unit of work may start. Work always starts as a whole block, sized by the selected operation. A cipher operation needs a whole block of input and room for a whole block of output, and both are checked together. A hash operation needs 16 input words, which is one 64-byte block, and it produces no output.

The engine receives a one-cycle start pulse together with the operation code. It then pops its input words, pushes its result words and signals completion. Only one block is in flight at a time.

Top module: `blk_sched_fifo`

## Requirements
- R1: After reset, both queues are empty, `status` reads 0x2000_0000, `start_vld` is low and `rd_data` is zero.
- R2: A host write (`wr_en`) is accepted into the input queue only while `enable` is high. A write made while `enable` is low leaves the input count unchanged.
- R3: A host write made while the input queue already holds 32 words is dropped. The input count stays at 32, unless the engine pops in the same cycle, in which case the count falls by one.
- R4: `rd_data` shows the oldest output word, or zero when the output queue is empty. A cycle with `rd_en` high removes that word. A read of an empty queue changes nothing.
- R5: `status[31:24]` equals 32 minus the input count. `status[23:16]` equals the output count. `status[15:0]` is zero. The counts are those left by the previous clock edge.
- R6: For a cipher operation, `start_vld` is high when the input count is at least the block size and the free output space (33 minus the output count) is at least the block size. Op code 0 has a 4-word block. Op codes 1 and 2 have a 2-word block.
- R7: For a hash operation (op codes 3 and 4), `start_vld` is high once the input count is at least 16, whatever the output count.
- R8: `start_vld` stays low for op codes 5 to 7 and while `enable` is low.
- R9: After a cycle with `start_vld` high, no further start is given until the cycle after the engine has asserted `eng_done`.
- R10: `eng_rd_data` shows the oldest input word, and `eng_rd` removes it. Words pushed with `eng_wr` join the output queue in the order they are pushed.
- R11: In a single cycle, a host push and an engine pop on the input queue both take effect. Likewise, an engine push and a host pop on the output queue both take effect. Each count changes by the net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable; gates host writes and dispatch |
| op_sel | input | 3 | Selected operation code |
| wr_en | input | 1 | Host write strobe to the input queue |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe; pops the output queue |
| rd_data | output | 32 | Oldest output word, zero when empty |
| status | output | 32 | Free input slots [31:24], output count [23:16] |
| start_vld | output | 1 | Start of one block for the engine |
| start_op | output | 3 | Operation that goes with `start_vld` |
| eng_rd | input | 1 | Engine pops one input word |
| eng_rd_data | output | 32 | Oldest input word |
| eng_wr | input | 1 | Engine pushes one result word |
| eng_wr_data | input | 32 | Engine result word |
| eng_done | input | 1 | Engine has finished the current block |

## Verification
Each queue has two owners. The host can push to the input queue in the same cycle that the engine pops it. The engine can push a result in the same cycle that the host pops the output. The interesting collisions are a push into a full input queue while the engine drains it, and a host read of an empty output queue while the engine's first result arrives. Long runs of random host strobes against a bench-side engine that pops and pushes at random rates provoke both collisions. After every edge, the bench compares the status counts, the head words and the start decision with queue models held in the bench.

// File: rtl/blk_sched_fifo.sv
module blk_sched_fifo #(
  parameter int DW        = 32,
  parameter int IN_DEPTH  = 32,
  parameter int OUT_DEPTH = 33,
  parameter int BLK_WIDE  = 4,
  parameter int BLK_NARW  = 2,
  parameter int HASH_BLK  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [2:0]    op_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [31:0]   status,
  output logic          start_vld,
  output logic [2:0]    start_op,
  input  logic          eng_rd,
  output logic [DW-1:0] eng_rd_data,
  input  logic          eng_wr,
  input  logic [DW-1:0] eng_wr_data,
  input  logic          eng_done
);
  localparam int IAW = $clog2(IN_DEPTH);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  localparam logic [ICW-1:0] IN_FULL  = ICW'(IN_DEPTH);
  localparam logic [OCW-1:0] OUT_FULL = OCW'(OUT_DEPTH);

  logic [DW-1:0]  in_mem  [IN_DEPTH];
  logic [DW-1:0]  out_mem [OUT_DEPTH];
  logic [IAW-1:0] in_wp, in_rp;
  logic [OAW-1:0] out_wp, out_rp;
  logic [ICW-1:0] in_cnt, need_in;
  logic [OCW-1:0] out_cnt, need_out, out_free;
  logic           op_ok, busy;

  wire push_in  = wr_en & enable & (in_cnt != IN_FULL);
  wire pop_in   = eng_rd & (in_cnt != '0);
  wire push_out = eng_wr & (out_cnt != OUT_FULL);
  wire pop_out  = rd_en & (out_cnt != '0);

  assign out_free    = OUT_FULL - out_cnt;
  assign eng_rd_data = in_mem[in_rp];
  assign rd_data     = (out_cnt != '0) ? out_mem[out_rp] : '0;
  assign status      = {8'(IN_DEPTH) - 8'(in_cnt), 8'(out_cnt), 16'h0000};
  assign start_op    = op_sel;

  always_comb begin
    op_ok    = 1'b1;
    need_in  = '0;
    need_out = '0;
    case (op_sel)
      3'd0: begin
        need_in  = ICW'(BLK_WIDE);
        need_out = OCW'(BLK_WIDE);
      end
      3'd1, 3'd2: begin
        need_in  = ICW'(BLK_NARW);
        need_out = OCW'(BLK_NARW);
      end
      3'd3, 3'd4: need_in = ICW'(HASH_BLK);
      default: op_ok = 1'b0;
    endcase
  end

  assign start_vld = enable & ~busy & op_ok & (in_cnt >= need_in) & (out_free >= need_out);

  always_ff @(posedge clk) begin
    if (push_in) in_mem[in_wp] <= wr_data;
    if (push_out) out_mem[out_wp] <= eng_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp   <= '0;
      in_rp   <= '0;
      in_cnt  <= '0;
      out_wp  <= '0;
      out_rp  <= '0;
      out_cnt <= '0;
      busy    <= 1'b0;
    end else begin
      if (push_in)  in_wp  <= (in_wp == IAW'(IN_DEPTH - 1)) ? '0 : in_wp + 1'b1;
      if (pop_in)   in_rp  <= (in_rp == IAW'(IN_DEPTH - 1)) ? '0 : in_rp + 1'b1;
      if (push_out) out_wp <= (out_wp == OAW'(OUT_DEPTH - 1)) ? '0 : out_wp + 1'b1;
      if (pop_out)  out_rp <= (out_rp == OAW'(OUT_DEPTH - 1)) ? '0 : out_rp + 1'b1;
      in_cnt  <= in_cnt + ICW'(push_in) - ICW'(pop_in);
      out_cnt <= out_cnt + OCW'(push_out) - OCW'(pop_out);
      if (start_vld)     busy <= 1'b1;
      else if (eng_done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/blk_sched_fifo_chk.sv
module blk_sched_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic [2:0]  op_sel,
  input logic        rd_en,
  input logic        eng_rd,
  input logic        eng_wr,
  input logic        start_vld,
  input logic [31:0] status
);
  // R9
  one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_vld |=> !start_vld);
  // R2
  wr_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !eng_rd) |=> $stable(status[31:24]));
  // R3
  in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:24] == 8'd0 && !eng_rd) |=> status[31:24] == 8'd0);
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && status[23:16] == 8'd0 && !eng_wr) |=> status[23:16] == 8'd0);
  // R6
  out_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 && status[23:16] > 8'd29) |-> !start_vld);
  // R7
  hash_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vld && (op_sel == 3'd3 || op_sel == 3'd4)) |-> status[31:24] <= 8'd16);
  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 3'd4 || !enable) |-> !start_vld);
endmodule

bind blk_sched_fifo blk_sched_fifo_chk u_chk (.*);

// File: tb/blk_sched_fifo_bench.sv
module blk_sched_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  op_sel = 3'd7;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data, status, eng_rd_data;
  logic        start_vld;
  logic [2:0]  start_op;
  logic        eng_rd = 1'b0, eng_wr = 1'b0, eng_done = 1'b0;
  logic [31:0] eng_wr_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_sched_fifo u_blk_sched_fifo (.*);

  int checks = 0, fails = 0;
  string stag = "R1";
  bit [31:0] in_q[$];
  bit [31:0] out_q[$];
  bit m_busy = 0, e_act = 0;
  int e_rd_left = 0, e_wr_left = 0, e_read = 0, e_written = 0;
  int eng_pct = 100;
  int wcount = 0;

  function automatic int nin(bit [2:0] o);
    case (o)
      3'd0: return 4;
      3'd1, 3'd2: return 2;
      3'd3, 3'd4: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int nout(bit [2:0] o);
    case (o)
      3'd0: return 4;
      3'd1, 3'd2: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic string start_tag(bit busy_m, bit en, bit [2:0] o);
    if (busy_m) return "R9";
    if (!en || o > 3'd4) return "R8";
    if (o >= 3'd3) return "R7";
    return "R6";
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit w, bit r, bit en, bit [2:0] o);
    bit st, er, ew, ed;
    int isz, osz;
    bit [31:0] wd;
    @(negedge clk);
    wd = $urandom;
    er = e_act && e_rd_left > 0 && ($urandom % 100 < eng_pct);
    ew = e_act && e_wr_left > 0 && e_written < e_read && ($urandom % 100 < eng_pct);
    ed = e_act && e_rd_left == 0 && e_wr_left == 0 && ($urandom % 100 < eng_pct);
    wr_en = w; wr_data = wd; rd_en = r; enable = en; op_sel = o;
    eng_rd = er; eng_wr = ew; eng_wr_data = $urandom; eng_done = ed;
    #1;
    isz = in_q.size();
    osz = out_q.size();
    chk(stag, "status", status, {8'(32 - isz), 8'(osz), 16'h0});
    chk(stag == "R5" ? "R4" : stag, "rd_data", rd_data, osz > 0 ? out_q[0] : 32'h0);
    st = en && !m_busy && o <= 3'd4 && isz >= nin(o) && (33 - osz) >= nout(o);
    chk(start_tag(m_busy, en, o), "start_vld", {31'h0, start_vld}, {31'h0, st});
    if (er) chk("R10", "eng_rd_data", eng_rd_data, in_q[0]);
    if (r && osz > 0) void'(out_q.pop_front());
    if (ew) out_q.push_back(eng_wr_data);
    if (er && isz > 0) void'(in_q.pop_front());
    if (w && en && isz < 32) in_q.push_back(wd);
    if (er) begin e_rd_left--; e_read++; end
    if (ew) begin e_wr_left--; e_written++; end
    if (ed) begin e_act = 0; m_busy = 0; end
    if (st) begin
      m_busy = 1; e_act = 1;
      e_rd_left = nin(o); e_wr_left = nout(o);
      e_read = 0; e_written = 0;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit [2:0] op;
    bit en;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    stag = "R1";
    step(0, 0, 1, 3'd0);
    // R2: writes while disabled are ignored
    stag = "R2";
    for (int i = 0; i < 5; i++) step(1, 0, 0, 3'd7);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 3'd7);
    // R3: overflow of the input queue
    stag = "R3";
    for (int i = 0; i < 35; i++) step(1, 0, 1, 3'd7);
    step(0, 0, 1, 3'd7);
    // R7: hash dispatch drains two blocks
    stag = "R7";
    for (int i = 0; i < 60; i++) step(0, 0, 1, 3'd3);
    // R6: output room limits cipher dispatch
    stag = "R6";
    for (int i = 0; i < 32; i++) step(1, 0, 1, 3'd0);
    for (int i = 0; i < 60; i++) step(0, 0, 1, 3'd0);
    for (int i = 0; i < 8; i++) step(1, 0, 1, 3'd0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 3'd1);
    stag = "R4";
    step(0, 1, 1, 3'd1);
    for (int i = 0; i < 10; i++) step(0, 0, 1, 3'd1);
    for (int i = 0; i < 40; i++) step(0, 1, 1, 3'd7);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 3'd7);
    // R8: reserved codes and disabled never start
    stag = "R8";
    for (int i = 0; i < 6; i++) step(1, 0, 1, 3'd5);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 3'd6);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 3'd0);
    // R5 / R11: random traffic with concurrent queue access
    op = 3'd0;
    en = 1;
    for (int i = 0; i < 4000; i++) begin
      stag = (i < 1500) ? "R5" : "R11";
      eng_pct = 40 + int'($urandom % 60);
      if ($urandom % 100 < 3) op = 3'($urandom % 8);
      if ($urandom % 100 < 2) en = ~en;
      if (op > 3'd4 && $urandom % 100 < 20) op = 3'($urandom % 5);
      step($urandom % 100 < 55, $urandom % 100 < 35, en, op);
    end
    finish_up();
  end
endmodule